// File: doc/BRIEF.md
# Cascadable Dual 8-bit Interval Timer

Two 8-bit up-counters, each compared against its own compare register. In the default mode each counter advances on count ticks, returns to zero on a match and pulses its own interrupt. The result is two independent periodic interrupts, each with a period of compare+1 ticks.

Setting a mode bit in the high timer's control register chains the two counters into one 16-bit interval timer. The low counter is the low byte and wraps freely. The high counter advances on each low-byte wrap. A match against the joined 16-bit compare value clears both counters and pulses the low interrupt. The high half still pulses its own interrupt, and software is expected to mask it.

In chained mode a count run starts only when the high enable is set before the low enable. From then on the low enable alone starts and stops the run. Compare registers can be changed only while both halves are stopped.

Top module: `cascade_timer`

## Requirements
- R1: Register write port, selected by `wr_addr_i`. Address 0 is the low control register (bit 0 enables the low timer). Address 1 is the high control register (bit 0 enables the high timer, bit 1 selects chained mode). Address 2 is the low compare value and address 3 is the high compare value. After reset all registers are zero and both interrupts are low.
- R2: In independent mode, an enabled timer's counter advances once per tick and clears to zero on the tick at which it equals its compare value. Its interrupt is a one-cycle pulse in the cycle after that tick, so pulses repeat every compare+1 ticks.
- R3: Counters advance only in cycles where `tick_i` is high. With ticks on every other cycle, the pulse spacing doubles.
- R4: In chained mode the low counter wraps from 0xFF to 0x00, and the high counter advances by one on each wrap.
- R5: In chained mode, when {high count, low count} equals {high compare, low compare}, both counters clear and `irq_lo_o` pulses. The interval is that 16-bit value plus 1 ticks.
- R6: In chained mode, `irq_hi_o` pulses once when the high counter advances to a value equal to the high compare value.
- R7: In chained mode, counting starts only when the low enable goes from 0 to 1 while the high enable is already 1. Enabling low first and then high does not start the count.
- R8: In chained mode, run and stop follow only the low enable. Clearing the high enable during a run has no effect, and clearing the low enable stops both counters.
- R9: Writes to either compare register while either half is running are ignored.
- R10: A stopped counter is held at zero, so every restart begins a full interval from zero.
- R11: In independent mode the high timer runs on its own enable with its own compare value, and pulses only `irq_hi_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | 8 | Register write data |
| tick_i | input | 1 | Count-clock enable |
| irq_lo_o | output | 1 | Low timer / 16-bit match interrupt pulse |
| irq_hi_o | output | 1 | High timer match interrupt pulse |

## Verification
The bench builds the block at its default 8-bit counter width, so a chained compare value of 0x0203 is reached in about 516 ticks. That keeps a low-byte wrap, a high-half advance and the high-half interrupt inside a short run. Intervals are measured as edge counts between pulses, so the compare+1 rule and the doubling under a half-rate tick are checked directly. The order of enable writes, the writes ignored while running and the chained stop are checked by whether the expected pulses appear and how far apart they are.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    ADDR_CTL_LO = 2'd0,
    ADDR_CTL_HI = 2'd1,
    ADDR_CMP_LO = 2'd2,
    ADDR_CMP_HI = 2'd3
  } reg_addr_e;

  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_CASC_BIT = 1;
endpackage

// File: rtl/tmr_cnt_unit.sv
module tmr_cnt_unit #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] cnt_o,
  output logic         match_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || clr_i)   cnt_q <= '0;
    else if (inc_i)             cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o   = cnt_q;
  assign match_o = (cnt_q == cmp_i);
endmodule

// File: rtl/tmr_run_ctrl.sv
module tmr_run_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic casc_i,
  input  logic en_lo_i,
  input  logic en_hi_i,
  input  logic lo_rise_i,
  output logic run_lo_o,
  output logic run_hi_o
);
  // set only when low enable rises with high enable already on
  logic seq_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seq_ok_q <= 1'b0;
    else if (lo_rise_i) seq_ok_q <= en_hi_i;
    else if (!en_lo_i)  seq_ok_q <= 1'b0;
  end

  assign run_lo_o = casc_i ? (en_lo_i && seq_ok_q) : en_lo_i;
  assign run_hi_o = casc_i ? run_lo_o : en_hi_i;
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             tick_i,
  output logic             irq_lo_o,
  output logic             irq_hi_o
);
  logic             en_lo_q, en_hi_q, casc_q;
  logic [CNT_W-1:0] cmp_lo_q, cmp_hi_q;
  logic             run_lo, run_hi, busy, lo_rise;
  logic [CNT_W-1:0] cnt_lo, cnt_hi, hi_next;
  logic             m_lo, m_hi, m16, full_lo;
  logic             step_lo, step_hi, clr_lo, clr_hi;
  logic             irq_lo_q, irq_hi_q;

  assign busy    = run_lo | run_hi;
  assign lo_rise = wr_en_i && (wr_addr_i == ADDR_CTL_LO) && wr_data_i[CTL_EN_BIT] && !en_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_lo_q  <= 1'b0;
      en_hi_q  <= 1'b0;
      casc_q   <= 1'b0;
      cmp_lo_q <= '0;
      cmp_hi_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_CTL_LO: en_lo_q <= wr_data_i[CTL_EN_BIT];
        ADDR_CTL_HI: begin
          en_hi_q <= wr_data_i[CTL_EN_BIT];
          casc_q  <= wr_data_i[CTL_CASC_BIT];
        end
        ADDR_CMP_LO: if (!busy) cmp_lo_q <= wr_data_i;
        ADDR_CMP_HI: if (!busy) cmp_hi_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  tmr_run_ctrl u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .casc_i    (casc_q),
    .en_lo_i   (en_lo_q),
    .en_hi_i   (en_hi_q),
    .lo_rise_i (lo_rise),
    .run_lo_o  (run_lo),
    .run_hi_o  (run_hi)
  );

  assign full_lo = &cnt_lo;
  assign m16     = m_lo & m_hi;
  assign hi_next = cnt_hi + CNT_W'(1);

  always_comb begin
    step_lo = tick_i & run_lo;
    if (casc_q) begin
      clr_lo  = step_lo & m16;
      step_hi = step_lo & full_lo;
      clr_hi  = step_lo & m16;
    end else begin
      clr_lo  = step_lo & m_lo;
      step_hi = tick_i & run_hi;
      clr_hi  = step_hi & m_hi;
    end
  end

  tmr_cnt_unit #(.W(CNT_W)) u_lo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_lo),
    .clr_i   (clr_lo),
    .inc_i   (step_lo),
    .cmp_i   (cmp_lo_q),
    .cnt_o   (cnt_lo),
    .match_o (m_lo)
  );

  tmr_cnt_unit #(.W(CNT_W)) u_hi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_hi),
    .clr_i   (clr_hi),
    .inc_i   (step_hi),
    .cmp_i   (cmp_hi_q),
    .cnt_o   (cnt_hi),
    .match_o (m_hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_lo_q <= 1'b0;
      irq_hi_q <= 1'b0;
    end else begin
      irq_lo_q <= clr_lo;
      // chained: high half flags when it steps onto its compare value
      irq_hi_q <= casc_q ? (step_hi & ~m16 & (hi_next == cmp_hi_q)) : clr_hi;
    end
  end

  assign irq_lo_o = irq_lo_q;
  assign irq_hi_o = irq_hi_q;
endmodule

// File: rtl/cascade_timer_chk.sv
module cascade_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic             tick_i,
  input logic             irq_lo_o,
  input logic             irq_hi_o,
  input logic             run_lo,
  input logic             run_hi,
  input logic             casc_q,
  input logic [CNT_W-1:0] cnt_lo,
  input logic [CNT_W-1:0] cnt_hi,
  input logic [CNT_W-1:0] cmp_lo_q,
  input logic [CNT_W-1:0] cmp_hi_q
);
  // R3
  lo_irq_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_lo_o |-> $past(tick_i));

  // R3
  hi_irq_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hi_o |-> $past(tick_i));

  // R3
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_lo && !tick_i) |=> $stable(cnt_lo));

  // R10
  stop_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_lo |=> (cnt_lo == '0));

  // R8
  casc_stop_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (casc_q && !run_lo) |=> (cnt_hi == '0));

  // R9
  cmp_lo_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd2 && (run_lo || run_hi)) |=> $stable(cmp_lo_q));

  // R9
  cmp_hi_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd3 && (run_lo || run_hi)) |=> $stable(cmp_hi_q));

  // R4
  carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (casc_q && run_lo && tick_i && (&cnt_lo) && ({cnt_hi, cnt_lo} != {cmp_hi_q, cmp_lo_q}))
    |=> (cnt_hi == CNT_W'($past(cnt_hi) + CNT_W'(1))) && (cnt_lo == '0));
endmodule

bind cascade_timer cascade_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .tick_i    (tick_i),
  .irq_lo_o  (irq_lo_o),
  .irq_hi_o  (irq_hi_o),
  .run_lo    (run_lo),
  .run_hi    (run_hi),
  .casc_q    (casc_q),
  .cnt_lo    (cnt_lo),
  .cnt_hi    (cnt_hi),
  .cmp_lo_q  (cmp_lo_q),
  .cmp_hi_q  (cmp_hi_q)
);

// File: tb/tb_cascade_timer.sv
`timescale 1ns/1ps
module tb_cascade_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b0;
  logic       irq_lo, irq_hi;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  cascade_timer dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .tick_i    (tick),
    .irq_lo_o  (irq_lo),
    .irq_hi_o  (irq_hi)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // edges until a pulse on the chosen output; maxc+1 if none
  task automatic wait_pulse(input bit hi, input int maxc, input bit toggle, output int n);
    n = maxc + 1;
    for (int i = 1; i <= maxc; i++) begin
      @(posedge clk); #1;
      if (toggle) tick = ~tick;
      if ((hi ? irq_hi : irq_lo) == 1'b1) begin
        n = i;
        break;
      end
    end
  endtask

  // count pulses on the chosen output over a window
  task automatic count_pulses(input bit hi, input int win, output int c);
    c = 0;
    for (int i = 0; i < win; i++) begin
      @(posedge clk); #1;
      if ((hi ? irq_hi : irq_lo) == 1'b1) c++;
    end
  endtask

  task automatic stop_all();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_reset();
    check("R1 irq_lo after reset", irq_lo, 0);
    check("R1 irq_hi after reset", irq_hi, 0);
  endtask

  task automatic t_indep_lo();
    int n, c;
    tick = 1'b1;
    wr(2'd2, 8'd4);
    wr(2'd0, 8'h01);
    wait_pulse(0, 50, 0, n);
    check("R2 first interval", n, 5);
    wait_pulse(0, 50, 0, n);
    check("R2 repeat interval", n, 5);
    @(posedge clk); #1;
    check("R2 one-cycle pulse", irq_lo, 0);
    // R9: compare write while running is ignored
    wr(2'd2, 8'd9);
    wait_pulse(0, 50, 0, n);
    wait_pulse(0, 50, 0, n);
    check("R9 interval after blocked write", n, 5);
    count_pulses(1, 20, c);
    check("R11 no hi pulse with hi disabled", c, 0);
    stop_all();
    // R10: restart from zero gives a full first interval
    wr(2'd0, 8'h01);
    wait_pulse(0, 50, 0, n);
    check("R10 restart interval", n, 5);
    stop_all();
  endtask

  task automatic t_tick_gate();
    int n;
    tick = 1'b1;
    wr(2'd2, 8'd3);
    wr(2'd0, 8'h01);
    wait_pulse(0, 50, 1, n);
    wait_pulse(0, 50, 1, n);
    check("R3 half-rate interval", n, 8);
    tick = 1'b1;
    stop_all();
  endtask

  task automatic t_indep_hi();
    int n, c;
    tick = 1'b1;
    wr(2'd3, 8'd2);
    wr(2'd1, 8'h01);
    wait_pulse(1, 50, 0, n);
    check("R11 hi first interval", n, 3);
    wait_pulse(1, 50, 0, n);
    check("R11 hi repeat interval", n, 3);
    count_pulses(0, 20, c);
    check("R11 lo silent", c, 0);
    stop_all();
  endtask

  task automatic t_cascade();
    int n, c;
    tick = 1'b1;
    wr(2'd2, 8'h03);
    wr(2'd3, 8'h02);
    wr(2'd1, 8'h03);   // chained, high enable first
    wr(2'd0, 8'h01);
    wait_pulse(1, 2000, 0, n);
    check("R6 hi pulse at advance to compare", n, 512);
    wait_pulse(0, 2000, 0, n);
    check("R4 R5 first 16-bit interval", 512 + n, 516);
    wait_pulse(0, 2000, 0, n);
    check("R5 repeat 16-bit interval", n, 516);
    // R8: dropping high enable does not stop the run
    wr(2'd1, 8'h02);
    wait_pulse(0, 2000, 0, n);
    wait_pulse(0, 2000, 0, n);
    check("R8 run survives hi enable clear", n, 516);
    // R8: clearing low enable stops both
    wr(2'd0, 8'h00);
    count_pulses(0, 1200, c);
    check("R8 stopped, no lo pulse", c, 0);
    stop_all();
  endtask

  task automatic t_order();
    int n, c;
    tick = 1'b1;
    wr(2'd2, 8'h03);
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h02);   // chained, high off
    wr(2'd0, 8'h01);   // low first
    wr(2'd1, 8'h03);   // then high
    count_pulses(0, 40, c);
    check("R7 wrong order does not start", c, 0);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h01);
    wait_pulse(0, 40, 0, n);
    check("R7 correct order starts", n, 4);
    stop_all();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_indep_lo();
    t_tick_gate();
    t_indep_hi();
    t_cascade();
    t_order();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule